// File: doc/BRIEF.md
# Multi-Bank DRAM Command Spacing Monitor

This block watches the command stream that a controller sends to a four-bank DRAM and keeps a copy of the open or closed state of every bank. For every command it decides whether the command came too early after an earlier one. The spacings it checks are activate to column access, activate to precharge, activate to activate, precharge to activate, write recovery, write to read, and the recovery after refresh and mode-register writes. Each spacing is a parameter counted in clock cycles. The block does not move data.

Each broken rule sets its own sticky bit in a violation vector. A second sticky vector marks the bank that a bank-specific rule was broken on. Both vectors hold until the clear input is pulsed. Commands are treated as executed even when they break a rule, so the tracked bank state always follows the stream exactly as it was sent. The end of write data is computed from the write command cycle, the write latency `WL` and the burst length `BL`. The last data beat lands `WEND = WL + BL/2 - 1` cycles after the write command.

Top module: `dram_timing_guard`

## Requirements
- R1: `cmd_i` is encoded as 0 idle, 1 activate, 2 read, 3 write, 4 precharge bank, 5 precharge all, 6 refresh, 7 mode-register write. From the cycle after the command, `bank_open_o[b]` reflects the bank state. Activate sets the bit, precharge clears it, precharge-all clears every bit, and a read or write with `ap_i` high clears it.
- R2: A read less than `T_RCD_RD` (5) cycles after the activate of its bank sets `viol_o[0]`. A write less than `T_RCD_WR` (3) cycles after that activate sets `viol_o[1]`.
- R3: A precharge or precharge-all that reaches an open bank less than `T_RAS` (11) cycles after its activate sets `viol_o[2]`.
- R4: An activate less than `T_RC` (16) cycles after the previous activate of the same bank sets `viol_o[3]`. An activate less than `T_RP` (5) cycles after a precharge of that bank sets `viol_o[4]`. A read with auto-precharge counts as a precharge issued `BL/2` cycles after the read.
- R5: An activate less than `T_RRD` (3) cycles after an activate of a different bank sets `viol_o[5]`.
- R6: A read or write less than `T_CCD` cycles after the previous read or write on any bank sets `viol_o[6]`.
- R7: A precharge of a bank less than `WEND + T_WR` cycles after a write to it sets `viol_o[7]`, with `T_WR` = 4. For precharge-all, any bank counts.
- R8: A read less than `WEND + T_WTR` cycles after any write sets `viol_o[8]`, with `T_WTR` = 3. This covers a read that would cut a write burst short.
- R9: An activate less than `WEND + T_DAL` cycles after a write with auto-precharge to the same bank sets `viol_o[9]`, with `T_DAL` = 9.
- R10: Any non-idle command less than `T_RFC` (17) cycles after a refresh, or less than `T_MRD` (2) cycles after a mode-register write, sets `viol_o[10]`.
- R11: A refresh or mode-register write issued while any bank is open sets `viol_o[11]`.
- R12: A read or write to a closed bank sets `viol_o[12]`. An activate to an open bank sets `viol_o[13]`.
- R13: Violation bits stay set until `clr_i`. In the cycle after a `clr_i` with an idle command, `viol_o` and `viol_bank_o` read zero. A rule tied to the addressed bank (R2, R4, R5, R9, R12, and R3/R7 on a single-bank precharge) also sets `viol_bank_o[bank_i]`.
- R14: After reset, all banks read closed, both violation vectors are zero, and every spacing window is expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command, encoding as in R1 |
| bank_i | input | 2 | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge flag on reads and writes |
| clr_i | input | 1 | Clears both sticky violation vectors |
| bank_open_o | output | 4 | Per-bank open state |
| viol_o | output | 14 | Sticky per-rule violation bits |
| viol_bank_o | output | 4 | Sticky per-bank violation marks |

## Verification
Every result is registered once, so a command sampled on one rising edge shows its effect on `bank_open_o`, `viol_o` and `viol_bank_o` from that edge on. The bench drives each command on a falling edge and reads the outputs on the next falling edge, half a cycle after the edge that captured the command. Each spacing rule is swept over gaps from one cycle up to just past its threshold, with a fresh reset before every gap. The expected bit is computed arithmetically from the threshold as gap < threshold.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   typedef enum logic [2:0] {
      C_NOP  = 3'd0,
      C_ACT  = 3'd1,
      C_RD   = 3'd2,
      C_WR   = 3'd3,
      C_PRE  = 3'd4,
      C_PREA = 3'd5,
      C_REF  = 3'd6,
      C_MRS  = 3'd7
   } dcmd_e;

   localparam int NRULE    = 14;
   localparam int V_RCD_RD = 0;
   localparam int V_RCD_WR = 1;
   localparam int V_RAS    = 2;
   localparam int V_RC     = 3;
   localparam int V_RP     = 4;
   localparam int V_RRD    = 5;
   localparam int V_CCD    = 6;
   localparam int V_WREC   = 7;
   localparam int V_WTR    = 8;
   localparam int V_DAL    = 9;
   localparam int V_BUSY   = 10;
   localparam int V_IDLE   = 11;
   localparam int V_CLOSED = 12;
   localparam int V_OPEN   = 13;

   // Per-bank "window still running" flags
   typedef struct packed {
      logic rcd_rd;
      logic rcd_wr;
      logic ras;
      logic rc;
      logic rp;
      logic rrd;
      logic wrec;
      logic dal;
   } bank_win_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dtg_gap_timer.sv
// Down-counter holding the cycles left before a spacing window expires.
// A load keeps the larger of the new value and the running remainder.
module dtg_gap_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         busy
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] dec;

   always_comb begin
      dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load && (load_val > dec)) begin
         cnt_q <= load_val;
      end else begin
         cnt_q <= dec;
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/dtg_bank_track.sv
// State and spacing windows of one bank.
module dtg_bank_track
   import dtg_pkg::*;
#(
   parameter int W         = 5,
   parameter int LD_RCD_RD = 4,
   parameter int LD_RCD_WR = 2,
   parameter int LD_RAS    = 10,
   parameter int LD_RC     = 15,
   parameter int LD_RP     = 4,
   parameter int LD_RP_AP  = 6,
   parameter int LD_RRD    = 2,
   parameter int LD_WREC   = 5,
   parameter int LD_DAL    = 10
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      act,
   input  logic      rd,
   input  logic      wr,
   input  logic      pre,
   input  logic      ap,
   output logic      open_o,
   output bank_win_t win_o
);

   logic         open_q;
   logic         rp_load;
   logic [W-1:0] rp_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
      end else if (act) begin
         open_q <= 1'b1;
      end else if (pre || ((rd || wr) && ap)) begin
         open_q <= 1'b0;
      end
   end

   assign open_o  = open_q;
   assign rp_load = pre || (rd && ap);
   assign rp_val  = pre ? W'(LD_RP) : W'(LD_RP_AP);

   dtg_gap_timer #(.W(W)) u_rcd_rd (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(W'(LD_RCD_RD)), .busy(win_o.rcd_rd));
   dtg_gap_timer #(.W(W)) u_rcd_wr (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(W'(LD_RCD_WR)), .busy(win_o.rcd_wr));
   dtg_gap_timer #(.W(W)) u_ras (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(W'(LD_RAS)), .busy(win_o.ras));
   dtg_gap_timer #(.W(W)) u_rc (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(W'(LD_RC)), .busy(win_o.rc));
   dtg_gap_timer #(.W(W)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(act), .load_val(W'(LD_RRD)), .busy(win_o.rrd));
   dtg_gap_timer #(.W(W)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(rp_load), .load_val(rp_val), .busy(win_o.rp));
   dtg_gap_timer #(.W(W)) u_wrec (
      .clk(clk), .rst_n(rst_n), .load(wr), .load_val(W'(LD_WREC)), .busy(win_o.wrec));
   dtg_gap_timer #(.W(W)) u_dal (
      .clk(clk), .rst_n(rst_n), .load(wr && ap), .load_val(W'(LD_DAL)), .busy(win_o.dal));

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
   import dtg_pkg::*;
#(
   parameter int NB       = 4,
   parameter int BL       = 4,
   parameter int WL       = 1,
   parameter int T_RCD_RD = 5,
   parameter int T_RCD_WR = 3,
   parameter int T_RAS    = 11,
   parameter int T_RC     = 16,
   parameter int T_RP     = 5,
   parameter int T_RRD    = 3,
   parameter int T_CCD    = 1,
   parameter int T_WR     = 4,
   parameter int T_WTR    = 3,
   parameter int T_DAL    = 9,
   parameter int T_RFC    = 17,
   parameter int T_MRD    = 2,
   localparam int BW      = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd_i,
   input  logic [BW-1:0]    bank_i,
   input  logic             ap_i,
   input  logic             clr_i,
   output logic [NB-1:0]    bank_open_o,
   output logic [NRULE-1:0] viol_o,
   output logic [NB-1:0]    viol_bank_o
);

   // Derived thresholds, in cycles from the command
   localparam int WEND     = WL + BL / 2 - 1;
   localparam int TH_WREC  = WEND + T_WR;
   localparam int TH_WTR   = WEND + T_WTR;
   localparam int TH_DAL   = WEND + T_DAL;
   localparam int TH_RP_AP = BL / 2 + T_RP;
   localparam int MAXT     = imax(imax(imax(T_RC, T_RFC), imax(TH_DAL, TH_RP_AP)),
                                  imax(imax(TH_WREC, TH_WTR), imax(T_RAS, T_MRD)));
   localparam int W        = $clog2(MAXT + 1);

   // Elaboration-time parameter checks
   if ((BL != 2) && (BL != 4) && (BL != 8)) begin : g_bad_bl
      $error("dram_timing_guard: BL must be 2, 4 or 8");
   end
   if ((NB < 2) || ((NB & (NB - 1)) != 0)) begin : g_bad_nb
      $error("dram_timing_guard: NB must be a power of two of at least 2");
   end
   if ((WL < 0) || (T_RCD_RD < 1) || (T_RCD_WR < 1) || (T_RAS < 1) || (T_RC < 1) ||
       (T_RP < 1) || (T_RRD < 1) || (T_CCD < 1) || (T_WR < 1) || (T_WTR < 1) ||
       (T_DAL < 1) || (T_RFC < 1) || (T_MRD < 1)) begin : g_bad_t
      $error("dram_timing_guard: spacings must be at least one cycle");
   end

   dcmd_e c;
   assign c = dcmd_e'(cmd_i);

   logic            is_act, is_rd, is_wr, is_pre, is_prea, is_ref, is_mrs, is_col;
   logic [NB-1:0]   sel;
   logic [NB-1:0]   open_v, ras_v, wrec_v, rrd_v;
   bank_win_t       win [NB];

   assign is_act  = (c == C_ACT);
   assign is_rd   = (c == C_RD);
   assign is_wr   = (c == C_WR);
   assign is_pre  = (c == C_PRE);
   assign is_prea = (c == C_PREA);
   assign is_ref  = (c == C_REF);
   assign is_mrs  = (c == C_MRS);
   assign is_col  = is_rd || is_wr;
   assign sel     = NB'(1) << bank_i;

   // One tracker per bank
   for (genvar b = 0; b < NB; b++) begin : g_bank
      dtg_bank_track #(
         .W        (W),
         .LD_RCD_RD(T_RCD_RD - 1),
         .LD_RCD_WR(T_RCD_WR - 1),
         .LD_RAS   (T_RAS - 1),
         .LD_RC    (T_RC - 1),
         .LD_RP    (T_RP - 1),
         .LD_RP_AP (TH_RP_AP - 1),
         .LD_RRD   (T_RRD - 1),
         .LD_WREC  (TH_WREC - 1),
         .LD_DAL   (TH_DAL - 1)
      ) u_trk (
         .clk   (clk),
         .rst_n (rst_n),
         .act   (is_act && sel[b]),
         .rd    (is_rd && sel[b]),
         .wr    (is_wr && sel[b]),
         .pre   ((is_pre && sel[b]) || is_prea),
         .ap    (ap_i),
         .open_o(open_v[b]),
         .win_o (win[b])
      );
      assign ras_v[b]  = win[b].ras;
      assign wrec_v[b] = win[b].wrec;
      assign rrd_v[b]  = win[b].rrd;
   end

   // Windows shared by all banks
   logic         ccd_busy, wtr_busy, cmd_busy;
   logic         busy_load;
   logic [W-1:0] busy_val;

   if (T_CCD > 1) begin : g_ccd_timer
      dtg_gap_timer #(.W(W)) u_ccd (
         .clk(clk), .rst_n(rst_n), .load(is_col), .load_val(W'(T_CCD - 1)), .busy(ccd_busy));
   end else begin : g_ccd_none
      assign ccd_busy = 1'b0;
   end

   dtg_gap_timer #(.W(W)) u_wtr (
      .clk(clk), .rst_n(rst_n), .load(is_wr), .load_val(W'(TH_WTR - 1)), .busy(wtr_busy));

   assign busy_load = is_ref || is_mrs;
   assign busy_val  = is_ref ? W'(T_RFC - 1) : W'(T_MRD - 1);

   dtg_gap_timer #(.W(W)) u_cmd_busy (
      .clk(clk), .rst_n(rst_n), .load(busy_load), .load_val(busy_val), .busy(cmd_busy));

   // Rule evaluation for the command of this cycle
   bank_win_t        tgt;
   logic             tgt_open;
   logic [NRULE-1:0] hit;
   logic             bank_rule;
   logic [NB-1:0]    hit_bank;

   always_comb begin
      tgt      = win[bank_i];
      tgt_open = open_v[bank_i];
      hit      = '0;

      hit[V_RCD_RD] = is_rd && tgt_open && tgt.rcd_rd;
      hit[V_RCD_WR] = is_wr && tgt_open && tgt.rcd_wr;
      hit[V_RAS]    = (is_pre && tgt_open && tgt.ras) || (is_prea && |(open_v & ras_v));
      hit[V_RC]     = is_act && tgt.rc;
      hit[V_RP]     = is_act && tgt.rp;
      hit[V_RRD]    = is_act && |(rrd_v & ~sel);
      hit[V_CCD]    = is_col && ccd_busy;
      hit[V_WREC]   = (is_pre && tgt.wrec) || (is_prea && |wrec_v);
      hit[V_WTR]    = is_rd && wtr_busy;
      hit[V_DAL]    = is_act && tgt.dal;
      hit[V_BUSY]   = (c != C_NOP) && cmd_busy;
      hit[V_IDLE]   = (is_ref || is_mrs) && |open_v;
      hit[V_CLOSED] = is_col && !tgt_open;
      hit[V_OPEN]   = is_act && tgt_open;

      bank_rule = hit[V_RCD_RD] || hit[V_RCD_WR] || hit[V_RC] || hit[V_RP] ||
                  hit[V_RRD] || hit[V_DAL] || hit[V_CLOSED] || hit[V_OPEN] ||
                  (is_pre && (hit[V_RAS] || hit[V_WREC]));

      hit_bank = bank_rule ? sel : '0;
      if (is_prea) begin
         hit_bank = hit_bank | (open_v & ras_v) | wrec_v;
      end
   end

   // Sticky violation capture
   logic [NRULE-1:0] viol_q;
   logic [NB-1:0]    vbank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_q  <= '0;
         vbank_q <= '0;
      end else begin
         viol_q  <= (clr_i ? '0 : viol_q) | hit;
         vbank_q <= (clr_i ? '0 : vbank_q) | hit_bank;
      end
   end

   assign bank_open_o = open_v;
   assign viol_o      = viol_q;
   assign viol_bank_o = vbank_q;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
   parameter int NB    = 4,
   parameter int BW    = 2,
   parameter int NR    = 14,
   parameter int T_RFC = 17
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    cmd_i,
   input logic [BW-1:0] bank_i,
   input logic          clr_i,
   input logic [NB-1:0] bank_open_o,
   input logic [NR-1:0] viol_o,
   input logic [NB-1:0] viol_bank_o
);

   logic [BW-1:0] bank_q;
   logic [2:0]    cmd_q;

   always_ff @(posedge clk) begin
      bank_q <= bank_i;
      cmd_q  <= cmd_i;
   end

   // R1: an activated bank reads open on the next cycle
   p_open_after_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd1) |=> bank_open_o[bank_q]);

   // R1: precharge-all leaves every bank closed
   p_prea_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd5) |=> (bank_open_o == '0));

   // R12: column command to a closed bank is flagged
   p_column_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (((cmd_i == 3'd2) || (cmd_i == 3'd3)) && !bank_open_o[bank_i]) |=> viol_o[12]);

   // R13: without a clear, no set violation bit drops
   p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

   // R13: clear with an idle command empties both vectors
   p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (cmd_i == 3'd0)) |=> ((viol_o == '0) && (viol_bank_o == '0)));

   // R10: a command right after a refresh is flagged
   p_ref_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((T_RFC > 1) && (cmd_q == 3'd6) && (cmd_i != 3'd0)) |=> viol_o[10]);

endmodule

bind dram_timing_guard dtg_checker #(
   .NB(NB), .BW(BW), .NR(dtg_pkg::NRULE), .T_RFC(T_RFC)
) u_dtg_checker (
   .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .clr_i(clr_i),
   .bank_open_o(bank_open_o), .viol_o(viol_o), .viol_bank_o(viol_bank_o)
);

// File: tb/dram_timing_guard_tb_top.sv
`timescale 1ns/1ps
module dram_timing_guard_tb_top;

   localparam int CCD_TB = 2;
   // Expected thresholds from the requirements (BL=4, WL=1 -> WEND=2)
   localparam int E_WEND = 1 + 4 / 2 - 1;
   localparam int E_RCDR = 5;
   localparam int E_RCDW = 3;
   localparam int E_RAS  = 11;
   localparam int E_RC   = 16;
   localparam int E_RP   = 5;
   localparam int E_RRD  = 3;
   localparam int E_WREC = E_WEND + 4;
   localparam int E_WTR  = E_WEND + 3;
   localparam int E_DAL  = E_WEND + 9;
   localparam int E_RFC  = 17;
   localparam int E_MRD  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_i = 3'd0;
   logic [1:0]  bank_i = 2'd0;
   logic        ap_i = 1'b0;
   logic        clr_i = 1'b0;
   logic [3:0]  bank_open_o;
   logic [13:0] viol_o;
   logic [3:0]  viol_bank_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dram_timing_guard #(.T_CCD(CCD_TB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
      .clr_i(clr_i), .bank_open_o(bank_open_o), .viol_o(viol_o), .viol_bank_o(viol_bank_o));

   task automatic chk(input string req, input int got, input int exp, input int gap);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s gap=%0d actual=%0h expected=%0h", req, gap, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_i = 3'd0; ap_i = 1'b0; clr_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic issue(input int cmd, input int bnk, input bit ap);
      cmd_i = cmd[2:0]; bank_i = bnk[1:0]; ap_i = ap;
      @(negedge clk);
      cmd_i = 3'd0; ap_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      do_reset();
      // R14: reset state
      chk("R14 open", bank_open_o, 0, 0);
      chk("R14 viol", viol_o, 0, 0);
      chk("R14 vbank", viol_bank_o, 0, 0);

      // R1: bank state tracking
      issue(1, 3, 0);
      chk("R1 act", bank_open_o, 4'b1000, 0);
      issue(1, 0, 0);
      chk("R1 act2", bank_open_o, 4'b1001, 0);
      idle(20);
      issue(4, 3, 0);
      chk("R1 pre", bank_open_o, 4'b0001, 0);
      issue(5, 0, 0);
      chk("R1 prea", bank_open_o, 4'b0000, 0);
      idle(20);
      issue(1, 1, 0); idle(10);
      issue(3, 1, 1);
      chk("R1 wr_ap", bank_open_o, 4'b0000, 0);

      // R2: activate to read / write
      for (int d = 1; d <= E_RCDR + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(d - 1); issue(2, 0, 0);
         chk("R2 rd", viol_o[0], int'(d < E_RCDR), d);
      end
      for (int d = 1; d <= E_RCDW + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(d - 1); issue(3, 0, 0);
         chk("R2 wr", viol_o[1], int'(d < E_RCDW), d);
      end
      // R3: activate to precharge
      for (int d = 1; d <= E_RAS + 1; d++) begin
         do_reset(); issue(1, 1, 0); idle(d - 1); issue(4, 1, 0);
         chk("R3 ras", viol_o[2], int'(d < E_RAS), d);
      end
      // R4: same-bank activate spacing and precharge-to-activate
      for (int e = 1; e <= 6; e++) begin
         do_reset(); issue(1, 2, 0); idle(E_RAS - 1); issue(4, 2, 0);
         idle(e - 1); issue(1, 2, 0);
         chk("R4 rc", viol_o[3], int'(E_RAS + e < E_RC), e);
         chk("R4 rp", viol_o[4], int'(e < E_RP), e);
      end
      // R5: different-bank activates
      for (int d = 1; d <= E_RRD + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(d - 1); issue(1, 1, 0);
         chk("R5 rrd", viol_o[5], int'(d < E_RRD), d);
      end
      // R6: column-to-column
      for (int d = 1; d <= CCD_TB + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(E_RCDR - 1); issue(2, 0, 0);
         idle(d - 1); issue(2, 0, 0);
         chk("R6 ccd", viol_o[6], int'(d < CCD_TB), d);
      end
      // R7: write recovery before precharge
      for (int d = 1; d <= E_WREC + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(E_RCDR - 1); issue(3, 0, 0);
         idle(d - 1); issue(4, 0, 0);
         chk("R7 wrec", viol_o[7], int'(d < E_WREC), d);
      end
      // R8: write to read
      for (int d = 1; d <= E_WTR + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(E_RCDR - 1); issue(3, 0, 0);
         idle(d - 1); issue(2, 0, 0);
         chk("R8 wtr", viol_o[8], int'(d < E_WTR), d);
      end
      // R9: write with auto-precharge to activate
      for (int d = 1; d <= E_DAL + 1; d++) begin
         do_reset(); issue(1, 0, 0); idle(E_RCDR - 1); issue(3, 0, 1);
         idle(d - 1); issue(1, 0, 0);
         chk("R9 dal", viol_o[9], int'(d < E_DAL), d);
      end
      // R10: refresh and mode-register recovery
      for (int d = 1; d <= E_RFC + 1; d++) begin
         do_reset(); issue(6, 0, 0); idle(d - 1); issue(1, 0, 0);
         chk("R10 rfc", viol_o[10], int'(d < E_RFC), d);
      end
      for (int d = 1; d <= E_MRD + 1; d++) begin
         do_reset(); issue(7, 0, 0); idle(d - 1); issue(1, 0, 0);
         chk("R10 mrd", viol_o[10], int'(d < E_MRD), d);
      end
      // R11: refresh / mode write with open bank
      do_reset(); issue(6, 0, 0);
      chk("R11 ref idle", viol_o[11], 0, 0);
      do_reset(); issue(1, 2, 0); idle(E_RAS); issue(6, 0, 0);
      chk("R11 ref open", viol_o[11], 1, 0);
      do_reset(); issue(1, 2, 0); idle(E_RAS); issue(7, 0, 0);
      chk("R11 mrs open", viol_o[11], 1, 0);
      // R12: closed / open bank misuse
      do_reset(); issue(2, 1, 0);
      chk("R12 rd closed", viol_o[12], 1, 0);
      do_reset(); issue(1, 1, 0); idle(E_RC); issue(1, 1, 0);
      chk("R12 act open", viol_o[13], 1, 0);
      chk("R12 act open rc ok", viol_o[3], 0, 0);
      // R13: bank mark, stickiness and clear
      do_reset(); issue(1, 2, 0); issue(2, 2, 0);
      chk("R13 vbank", viol_bank_o, 4'b0100, 1);
      idle(30);
      chk("R13 sticky", viol_o[0], 1, 30);
      clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
      chk("R13 clear", viol_o, 0, 0);
      chk("R13 clear bank", viol_bank_o, 0, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule